// File: doc/BRIEF.md
# PWM Generator with Dead Band

This block produces a pair of pulse-width-modulated outputs from a single 16-bit counter. The counter runs either as a down counter that reloads from a period value, which gives edge-aligned waveforms, or as an up/down counter that rises to the period value and falls back to zero, which gives center-aligned waveforms. Four events are decoded from the counter: reaching zero, reaching the period value, matching compare value A and matching compare value B. For each output, a 12-bit action table says how each event changes that output's raw level. The table has separate entries for compare matches while rising and while falling.

The two raw levels then pass through an optional dead-band stage. When this stage is enabled, a complementary pair is made from raw output 0, and each output's rising edge is held back by its own programmable count of clock cycles. When it is disabled, both raw levels pass straight through. A final stage applies a per-pin enable and inversion. While the fault input is high, both pins are forced to a programmed safe level. New period and compare values either take effect at once or are held in shadow registers until the counter reaches zero.

Top module: `pwm_dbgen`

## Requirements
- R1: While `rst` is high, and after it falls with `run` low, `pwm_out` is 2'b00, `pwm_evt` is 4'b0000 and the counter stands at zero.
- R2: With `updown`=0 the counter steps down by one on each clock while `run` is high, and at zero it reloads the period value, so one period is period+1 cycles. `pwm_evt` is a one-cycle-per-state flag vector that shows the current counter state: bit 0 is zero, bit 1 is equal to the period value, bit 2 is a match on compare A and bit 3 is a match on compare B.
- R3: With `updown`=1 the counter counts 0 up to the period value and back down to 0, so one period is 2×period cycles. Compare matches while rising use the "up" action fields, and matches while falling or in down mode use the "down" fields.
- R4: Each 2-bit action encodes 00 keep, 01 toggle, 10 drive low, 11 drive high. The action word is laid out as [1:0] at zero, [3:2] at period, [5:4] compare A rising, [7:6] compare A falling, [9:8] compare B rising, [11:10] compare B falling. A raw output changes on the clock edge that ends the cycle in which its event is flagged, and it holds when no event is flagged.
- R5: When several events are flagged in one cycle, their actions are applied in the order zero, period, compare A, compare B, so the later one wins.
- R6: While `run` is low, the counter holds its value, `pwm_evt` is 0 and the raw outputs hold.
- R7: With `sync_upd`=0, new period and compare inputs are used at once. With `sync_upd`=1 they are captured only in a cycle where the counter is zero and `run` is high, and are used from that cycle on.
- R8: With `db_en`=1, pin 0 follows raw output 0, and its rising edge is delayed by `db_rise` cycles. Pin 1 follows the inverse of raw output 0, and its rising edge is delayed by `db_fall` cycles. Both falls are immediate, and the two are never high together.
- R9: With `db_en`=0, raw output 0 drives pin 0 and raw output 1 drives pin 1 unchanged.
- R10: Bit g of `out_inv` inverts pin g. A pin whose `out_en` bit is 0 drives 0 whatever its inversion.
- R11: While `fault` is high, `pwm_out` equals `fault_lvl` in the same cycle, overriding enable and inversion. Normal levels return when `fault` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counter and event enable |
| updown | input | 1 | 0 down counting, 1 up/down counting |
| sync_upd | input | 1 | 1 holds new period/compare values until counter zero |
| load_val | input | 16 | Period value |
| cmpa_val | input | 16 | Compare value A |
| cmpb_val | input | 16 | Compare value B |
| act_a | input | 12 | Action table for raw output 0 |
| act_b | input | 12 | Action table for raw output 1 |
| db_en | input | 1 | Dead-band stage enable |
| db_rise | input | 12 | Rising-edge delay of pin 0, in cycles |
| db_fall | input | 12 | Rising-edge delay of pin 1, in cycles |
| out_en | input | 2 | Per-pin output enable |
| out_inv | input | 2 | Per-pin inversion |
| fault | input | 1 | Fault force request |
| fault_lvl | input | 2 | Pin levels while fault is high |
| pwm_out | output | 2 | PWM pins |
| pwm_evt | output | 4 | Event flags {cmpB, cmpA, period, zero} |

## Verification
Several properties are checked on every cycle:
- the down-count step and the reload from the period value;
- the turn-around at the top in up/down mode;
- the frozen counter while `run` is low;
- shadow values that stay unchanged away from counter zero in synchronized mode;
- raw levels that hold in cycles without events;
- a delayed rising edge that only follows a high input;
- complementary dead-band pins that never overlap.

Other behaviours show only in the bench's scenarios, because each is a cycle-exact waveform shape or depends on configuration:
- the edge-aligned and center-aligned waveform shapes;
- the action encoding and the priority between coincident events;
- the moment a held compare value starts to act;
- the exact dead-band widths;
- inversion, enable gating and fault forcing.

// File: rtl/pwmg_pkg.sv
package pwmg_pkg;

    localparam int NCH   = 2;   // number of PWM pins
    localparam int NEVT  = 4;   // number of counter events

    // 2-bit action applied to a raw output when an event is flagged
    typedef enum logic [1:0] {
        ACT_KEEP   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } act_e;

    // action table of one output, MSB first
    typedef struct packed {
        act_e cmpb_dn;
        act_e cmpb_up;
        act_e cmpa_dn;
        act_e cmpa_up;
        act_e at_load;
        act_e at_zero;
    } act_tbl_t;

    localparam int ACT_W = $bits(act_tbl_t);

    // event flags, bit 0 = zero
    typedef struct packed {
        logic cmpb;
        logic cmpa;
        logic at_load;
        logic at_zero;
    } evt_t;

    function automatic logic apply_act(input logic cur, input act_e a);
        logic r;
        unique case (a)
            ACT_KEEP:   r = cur;
            ACT_TOGGLE: r = ~cur;
            ACT_LOW:    r = 1'b0;
            default:    r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwmg_counter.sv
module pwmg_counter
    import pwmg_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          updown,
    input  logic          sync_upd,
    input  logic [CW-1:0] load_in,
    input  logic [CW-1:0] cmpa_in,
    input  logic [CW-1:0] cmpb_in,
    output evt_t          evt_o,
    output logic          dir_up_o
);

    logic [CW-1:0] cnt_q, cnt_nxt;
    logic [CW-1:0] load_sh, cmpa_sh, cmpb_sh;
    logic [CW-1:0] load_c, cmpa_c, cmpb_c;
    logic          dir_q;
    logic          at_zero, take, going_up;

    assign at_zero = (cnt_q == '0);
    // new values are taken every cycle in immediate mode, at zero otherwise
    assign take    = !sync_upd || (run && at_zero);

    assign load_c  = take ? load_in : load_sh;
    assign cmpa_c  = take ? cmpa_in : cmpa_sh;
    assign cmpb_c  = take ? cmpb_in : cmpb_sh;

    // direction of the step leaving the current count
    assign going_up = updown && (cnt_q < load_c) && (at_zero || dir_q);

    always_comb begin
        if (going_up)
            cnt_nxt = cnt_q + 1'b1;
        else if (at_zero)
            cnt_nxt = load_c;
        else
            cnt_nxt = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
        end else if (run) begin
            cnt_q <= cnt_nxt;
            dir_q <= going_up;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_sh <= '0;
            cmpa_sh <= '0;
            cmpb_sh <= '0;
        end else if (take) begin
            load_sh <= load_in;
            cmpa_sh <= cmpa_in;
            cmpb_sh <= cmpb_in;
        end
    end

    always_comb begin
        evt_o.at_zero = run && at_zero;
        evt_o.at_load = run && (cnt_q == load_c);
        evt_o.cmpa    = run && (cnt_q == cmpa_c);
        evt_o.cmpb    = run && (cnt_q == cmpb_c);
    end

    assign dir_up_o = going_up;

    // R2: one step down per enabled cycle in down mode
    a_r2_down_step: assert property (@(posedge clk) disable iff (rst)
        (run && !updown && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R2: reload from the period value at zero in down mode
    a_r2_reload: assert property (@(posedge clk) disable iff (rst)
        (run && !updown && at_zero) |=> (cnt_q == $past(load_c)));

    // R3: at the top of an up/down period the counter turns downward
    a_r3_turn_down: assert property (@(posedge clk) disable iff (rst)
        (run && updown && !at_zero && (cnt_q == load_c)) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R6: counter frozen while not running
    a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(cnt_q));

    // R7: held values change only at a running zero in synchronized mode
    a_r7_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        (sync_upd && !(run && at_zero)) |=>
            ($stable(load_sh) && $stable(cmpa_sh) && $stable(cmpb_sh)));

endmodule

// File: rtl/pwmg_action.sv
module pwmg_action
    import pwmg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_t     evt_i,
    input  logic     dir_up_i,
    input  act_tbl_t tbl_i,
    output logic     raw_o
);

    logic raw_q, raw_nxt;

    // fixed application order: zero, period, compare A, compare B
    always_comb begin
        raw_nxt = raw_q;
        if (evt_i.at_zero)
            raw_nxt = apply_act(raw_nxt, tbl_i.at_zero);
        if (evt_i.at_load)
            raw_nxt = apply_act(raw_nxt, tbl_i.at_load);
        if (evt_i.cmpa)
            raw_nxt = apply_act(raw_nxt, dir_up_i ? tbl_i.cmpa_up : tbl_i.cmpa_dn);
        if (evt_i.cmpb)
            raw_nxt = apply_act(raw_nxt, dir_up_i ? tbl_i.cmpb_up : tbl_i.cmpb_dn);
    end

    always_ff @(posedge clk) begin
        if (rst)
            raw_q <= 1'b0;
        else
            raw_q <= raw_nxt;
    end

    assign raw_o = raw_q;

    // R4: a raw level holds through cycles without events
    a_r4_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        (evt_i == '0) |=> $stable(raw_o));

endmodule

// File: rtl/pwmg_edge_dly.sv
module pwmg_edge_dly #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_i,
    input  logic [DW-1:0] dly_i,
    output logic          out_o
);

    logic [DW-1:0] wait_q;

    // counts cycles the input has been high, saturating at the delay
    always_ff @(posedge clk) begin
        if (rst || !in_i)
            wait_q <= '0;
        else if (wait_q < dly_i)
            wait_q <= wait_q + 1'b1;
    end

    assign out_o = in_i && (wait_q >= dly_i);

    // R8: with a nonzero delay a rising output follows a high input
    a_r8_rise_waits: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_o) && (dly_i != '0)) |-> $past(in_i));

endmodule

// File: rtl/pwm_dbgen.sv
module pwm_dbgen
    import pwmg_pkg::*;
#(
    parameter int CW = 16,
    parameter int DW = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             updown,
    input  logic             sync_upd,
    input  logic [CW-1:0]    load_val,
    input  logic [CW-1:0]    cmpa_val,
    input  logic [CW-1:0]    cmpb_val,
    input  logic [ACT_W-1:0] act_a,
    input  logic [ACT_W-1:0] act_b,
    input  logic             db_en,
    input  logic [DW-1:0]    db_rise,
    input  logic [DW-1:0]    db_fall,
    input  logic [NCH-1:0]   out_en,
    input  logic [NCH-1:0]   out_inv,
    input  logic             fault,
    input  logic [NCH-1:0]   fault_lvl,
    output logic [NCH-1:0]   pwm_out,
    output logic [NEVT-1:0]  pwm_evt
);

    evt_t           evt;
    logic           dir_up;
    logic [NCH-1:0] raw;
    logic [NCH-1:0] shaped;
    logic           dly_t, dly_c;
    act_tbl_t       tbl [NCH];

    assign tbl[0] = act_tbl_t'(act_a);
    assign tbl[1] = act_tbl_t'(act_b);

    pwmg_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .updown   (updown),
        .sync_upd (sync_upd),
        .load_in  (load_val),
        .cmpa_in  (cmpa_val),
        .cmpb_in  (cmpb_val),
        .evt_o    (evt),
        .dir_up_o (dir_up)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_act
        pwmg_action u_act (
            .clk      (clk),
            .rst      (rst),
            .evt_i    (evt),
            .dir_up_i (dir_up),
            .tbl_i    (tbl[g]),
            .raw_o    (raw[g])
        );
    end

    // dead band: true side and complement both made from raw output 0
    pwmg_edge_dly #(.DW(DW)) u_dly_t (
        .clk   (clk),
        .rst   (rst),
        .in_i  (raw[0]),
        .dly_i (db_rise),
        .out_o (dly_t)
    );

    pwmg_edge_dly #(.DW(DW)) u_dly_c (
        .clk   (clk),
        .rst   (rst),
        .in_i  (~raw[0]),
        .dly_i (db_fall),
        .out_o (dly_c)
    );

    assign shaped = db_en ? {dly_c, dly_t} : raw;

    for (genvar g = 0; g < NCH; g++) begin : g_pin
        assign pwm_out[g] = fault ? fault_lvl[g]
                                  : (out_en[g] & (shaped[g] ^ out_inv[g]));
    end

    assign pwm_evt = evt;

    // R8: complementary dead-band pair never high together
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
        db_en |-> !(dly_t && dly_c));

endmodule

// File: tb/pwm_dbgen_bench.sv
module pwm_dbgen_bench;

    logic        clk = 1'b0;
    logic        rst, run, updown, sync_upd, db_en, fault;
    logic [15:0] load_val, cmpa_val, cmpb_val;
    logic [11:0] act_a, act_b, db_rise, db_fall;
    logic [1:0]  out_en, out_inv, fault_lvl, pwm_out;
    logic [3:0]  pwm_evt;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pwm_dbgen u_pwm_dbgen (
        .clk(clk), .rst(rst), .run(run), .updown(updown), .sync_upd(sync_upd),
        .load_val(load_val), .cmpa_val(cmpa_val), .cmpb_val(cmpb_val),
        .act_a(act_a), .act_b(act_b), .db_en(db_en), .db_rise(db_rise),
        .db_fall(db_fall), .out_en(out_en), .out_inv(out_inv), .fault(fault),
        .fault_lvl(fault_lvl), .pwm_out(pwm_out), .pwm_evt(pwm_evt)
    );

    // down mode, period 4, A=3, B=1; {evt, out} after each edge (R2, R4, R9)
    localparam logic [5:0] VEC [0:11] = '{
        6'b0010_10, 6'b0100_11, 6'b0000_10, 6'b1000_10,
        6'b0001_10, 6'b0010_00, 6'b0100_01, 6'b0000_00,
        6'b1000_00, 6'b0001_10, 6'b0010_00, 6'b0100_01
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic hold_reset();
        rst = 1'b1;
        run = 1'b0;
        step(2);
    endtask

    task automatic go();
        rst = 1'b0;
        run = 1'b1;
    endtask

    initial begin
        #(20 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; run = 1'b0; updown = 1'b0; sync_upd = 1'b0;
        load_val = 16'd4; cmpa_val = 16'd3; cmpb_val = 16'd1;
        act_a = 12'h08C; act_b = 12'hC01;
        db_en = 1'b0; db_rise = '0; db_fall = '0;
        out_en = 2'b11; out_inv = 2'b00; fault = 1'b0; fault_lvl = 2'b00;
        @(negedge clk);
        step(2);
        check("R1 out in reset", {6'd0, pwm_out}, 8'h00);
        check("R1 evt in reset", {4'd0, pwm_evt}, 8'h00);
        rst = 1'b0;
        step(2);
        check("R1 out idle after reset", {6'd0, pwm_out}, 8'h00);
        check("R1 evt idle after reset", {4'd0, pwm_evt}, 8'h00);

        // table walk: edge-aligned waveform, bypass dead band
        run = 1'b1;
        for (int i = 0; i < 12; i++) begin
            step(1);
            check("R2/R4/R9 down-mode vector", {2'd0, pwm_evt, pwm_out}, {2'd0, VEC[i]});
        end

        // R6: stop counting, raw a=1 b=0 held
        run = 1'b0;
        #1 check("R6 no events when stopped", {4'd0, pwm_evt}, 8'h00);
        step(3);
        check("R6 outputs held", {6'd0, pwm_out}, 8'h01);
        check("R6 evt held zero", {4'd0, pwm_evt}, 8'h00);

        // R10: inversion and enable
        out_inv = 2'b01;
        #1 check("R10 invert pin0", {6'd0, pwm_out}, 8'h00);
        out_inv = 2'b11;
        #1 check("R10 invert both", {6'd0, pwm_out}, 8'h02);
        out_inv = 2'b10; out_en = 2'b01;
        #1 check("R10 disabled pin drives 0", {6'd0, pwm_out}, 8'h01);
        out_inv = 2'b00; out_en = 2'b11;

        // R11: fault override
        fault = 1'b1; fault_lvl = 2'b10;
        #1 check("R11 fault level 10", {6'd0, pwm_out}, 8'h02);
        fault_lvl = 2'b00;
        #1 check("R11 fault level 00", {6'd0, pwm_out}, 8'h00);
        fault = 1'b0;
        #1 check("R11 release restores", {6'd0, pwm_out}, 8'h01);
        step(1);

        // R3: up/down, period 3, A=2 high rising / low falling
        hold_reset();
        updown = 1'b1; load_val = 16'd3; cmpa_val = 16'd2; cmpb_val = 16'd9;
        act_a = 12'h0B0; act_b = 12'h000;
        go();
        step(2);
        check("R3 rising cmpA event", {2'd0, pwm_evt, pwm_out}, 8'b0100_00);
        step(1);
        check("R3 up action at top", {2'd0, pwm_evt, pwm_out}, 8'b0010_01);
        step(1);
        check("R3 falling cmpA event", {2'd0, pwm_evt, pwm_out}, 8'b0100_01);
        step(1);
        check("R3 down action low", {2'd0, pwm_evt, pwm_out}, 8'b0000_00);
        step(1);
        check("R3 bottom zero", {2'd0, pwm_evt, pwm_out}, 8'b0001_00);
        step(3);
        check("R3 period of 2L", {2'd0, pwm_evt, pwm_out}, 8'b0010_01);

        // R7: synchronized update of compare A
        hold_reset();
        updown = 1'b0; sync_upd = 1'b1; load_val = 16'd4; cmpa_val = 16'd2;
        act_a = 12'h083;
        go();
        step(1);
        check("R7 zero sets high", {6'd0, pwm_out}, 8'h01);
        cmpa_val = 16'd3;
        step(2);
        check("R7 new compare not yet used", {6'd0, pwm_out}, 8'h01);
        step(1);
        check("R7 held compare used", {6'd0, pwm_out}, 8'h00);
        step(3);
        check("R7 after zero, still high", {6'd0, pwm_out}, 8'h01);
        step(1);
        check("R7 new compare used after zero", {6'd0, pwm_out}, 8'h00);

        // R5: coincident events with period 0
        hold_reset();
        sync_upd = 1'b0; load_val = 16'd0; cmpa_val = 16'd5; act_a = 12'h00B;
        go();
        step(1);
        check("R5 period beats zero", {2'd0, pwm_evt, pwm_out}, 8'b0011_00);
        hold_reset();
        cmpa_val = 16'd0; act_a = 12'h0CB;
        go();
        step(1);
        check("R5 compare beats period", {2'd0, pwm_evt, pwm_out}, 8'b0111_01);

        // R8: dead band, rise 3, fall 2
        hold_reset();
        load_val = 16'd9; cmpa_val = 16'd5; act_a = 12'h083;
        db_en = 1'b1; db_rise = 12'd3; db_fall = 12'd2;
        go();
        step(1);
        check("R8 true rise delayed", {6'd0, pwm_out}, 8'h00);
        step(2);
        check("R8 true still waiting", {6'd0, pwm_out}, 8'h00);
        step(1);
        check("R8 true rises after 3", {6'd0, pwm_out}, 8'h01);
        step(2);
        check("R8 true falls at once", {6'd0, pwm_out}, 8'h00);
        step(1);
        check("R8 complement waiting", {6'd0, pwm_out}, 8'h00);
        step(1);
        check("R8 complement rises after 2", {6'd0, pwm_out}, 8'h02);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule